// File: doc/BRIEF.md
# Page Table Walk Unit

This block turns a virtual address into a physical address. It reads one entry from a single-level page table that sits in physical memory. A requester presents a virtual address, an access kind (load or store) and the base of the page table. The unit then builds the entry address by placing the base above the virtual page number. It issues one read on its memory port and waits for the answer, however long that takes. It then inspects the returned entry.

The result comes back as a one-cycle done strobe. With it comes either a physical address or exactly one of two faults. The not-present fault means the page is not resident. The protection fault means the access kind is forbidden on that page. Pages are 1 KB, so the low ten bits of the virtual address go straight into the physical address. The unit works on one walk at a time and is not ready for a new request until the current walk has finished.

Top module: `ptw_unit`

## Requirements
- R1: After reset the unit is ready (`req_ready`=1), with `done`, both fault outputs, `mem_req_valid` and `pa` all at 0.
- R2: One cycle after a request is accepted, `mem_req_valid` is 1 for exactly one cycle. `mem_req_addr` is then the concatenation {table base, VA[15:10]}, so it equals base*64 + VA/1024. Base and VA are the values captured at acceptance.
- R3: A request is accepted only while `req_ready` is 1. `req_ready` drops in the cycle after acceptance and returns only after the done cycle. A request raised while busy is ignored and does not change the result of the walk in progress.
- R4: Layout of the page-table entry: bit 0 is the resident flag, bit 1 is write permission, bit 2 is read permission, and bits [10:3] hold the 8-bit frame number.
- R5: If bit 0 of the entry is 0, the walk ends with `fault_absent`=1, `fault_perm`=0 and `pa`=0, whatever the permission bits say.
- R6: On a resident page, a store with bit 1 clear or a load with bit 2 clear ends with `fault_perm`=1, `fault_absent`=0 and `pa`=0. A store needs only bit 1, and a load needs only bit 2.
- R7: A permitted access ends with both faults at 0 and `pa` = {frame, VA[9:0]}, which equals frame*1024 + VA mod 1024.
- R8: `done` is 1 for exactly one cycle per walk, in the cycle after the response is taken. The fault outputs and a non-zero `pa` appear only in that cycle.
- R9: The response may arrive any number of cycles (at least one) after the request. `mem_rsp_valid` is ignored unless a response is awaited: a stray response while idle produces no `done` and no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_va | input | 16 | Virtual address to translate |
| req_write | input | 1 | 1 = store, 0 = load |
| table_base | input | 8 | Page-table base, upper part of entry address |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | 14 | Entry address {base, page number} |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 11 | Page-table entry returned by memory |
| done | output | 1 | Walk finished (one cycle) |
| pa | output | 18 | Physical address, valid with done and no fault |
| fault_absent | output | 1 | Page not resident |
| fault_perm | output | 1 | Access kind not permitted |

## Verification
The memory read is due in the cycle after acceptance. The bench samples `mem_req_valid` and the entry address at the falling edge that follows the accepting rising edge. Results are due one cycle after the edge that takes the response. So the bench raises `mem_rsp_valid` at a falling edge chosen by the vector's latency and checks `done`, `pa` and the faults at the very next falling edge. One cycle after that it checks that `done` has dropped and `req_ready` has returned. During the waiting cycles it checks that neither `done` nor a second read appears, so an early or doubled result is caught at the cycle where it happens.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } walk_state_t;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_ABSENT = 2'd1,
    RES_PERM   = 2'd2
  } walk_result_t;

  // Flag positions inside a page-table entry; the frame number sits above them.
  localparam int PTE_RESIDENT_BIT = 0;
  localparam int PTE_WRITE_BIT    = 1;
  localparam int PTE_READ_BIT     = 2;
  localparam int PTE_FLAG_BITS    = 3;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W   = 16,
  parameter int OFF_W  = 10,
  parameter int BASE_W = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int ADDR_W = BASE_W + VPN_W
) (
  input  logic [VA_W-1:0]   va,
  input  logic [BASE_W-1:0] base,
  output logic [ADDR_W-1:0] entry_addr,
  output logic [OFF_W-1:0]  offset
);

  // Entry address: base placed directly above the page number, no adder.
  function automatic logic [ADDR_W-1:0] form_entry_addr(
    input logic [BASE_W-1:0] b,
    input logic [VPN_W-1:0]  vpn
  );
    return {b, vpn};
  endfunction

  always_comb begin
    entry_addr = form_entry_addr(base, va[VA_W-1:OFF_W]);
    offset     = va[OFF_W-1:0];
  end

endmodule

// File: rtl/ptw_check.sv
module ptw_check
  import ptw_pkg::*;
#(
  parameter int PFN_W = 8,
  parameter int OFF_W = 10,
  localparam int PTE_W = PFN_W + PTE_FLAG_BITS,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  input  logic [OFF_W-1:0] offset,
  output walk_result_t     result,
  output logic [PA_W-1:0]  pa
);

  // Residency is tested first; rights only matter for a resident page.
  function automatic walk_result_t classify(
    input logic [PTE_W-1:0] e,
    input logic             wr
  );
    if (!e[PTE_RESIDENT_BIT])
      return RES_ABSENT;
    if (wr && !e[PTE_WRITE_BIT])
      return RES_PERM;
    if (!wr && !e[PTE_READ_BIT])
      return RES_PERM;
    return RES_OK;
  endfunction

  function automatic logic [PA_W-1:0] join_frame(
    input logic [PTE_W-1:0] e,
    input logic [OFF_W-1:0] off
  );
    return {e[PTE_W-1:PTE_FLAG_BITS], off};
  endfunction

  always_comb begin
    result = classify(pte, is_write);
    pa     = (result == RES_OK) ? join_frame(pte, offset) : '0;
  end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rsp_valid,
  output logic ready,
  output logic accept,
  output logic issue,
  output logic capture,
  output logic finish
);

  walk_state_t state_q, state_d;

  always_comb begin
    ready   = (state_q == ST_IDLE);
    accept  = ready && req_valid;
    issue   = (state_q == ST_ISSUE);
    capture = (state_q == ST_WAIT) && rsp_valid;
    finish  = (state_q == ST_FIN);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R2: the read goes out in the cycle right after acceptance.
  assert_issue_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> issue);

  // R8: a taken response leads to the finish cycle next.
  assert_finish_after_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> finish);

  // R9: waiting continues for as long as no response shows up.
  assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !rsp_valid) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/ptw_unit.sv
module ptw_unit
  import ptw_pkg::*;
#(
  parameter int VA_W   = 16,
  parameter int OFF_W  = 10,
  parameter int BASE_W = 8,
  parameter int PFN_W  = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int ADDR_W = BASE_W + VPN_W,
  localparam int PTE_W  = PFN_W + PTE_FLAG_BITS,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  input  logic [BASE_W-1:0] table_base,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic [PA_W-1:0]   pa,
  output logic              fault_absent,
  output logic              fault_perm
);

  // Internal events, named for the assertions.
  logic ev_accept, ev_issue, ev_capture, ev_finish;

  logic [VA_W-1:0]   va_q;
  logic              write_q;
  logic [BASE_W-1:0] base_q;

  logic [ADDR_W-1:0] entry_addr;
  logic [OFF_W-1:0]  offset;
  walk_result_t      chk_result;
  logic [PA_W-1:0]   chk_pa;

  logic [PA_W-1:0]   pa_q;
  logic              absent_q, perm_q;

  ptw_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (mem_rsp_valid),
    .ready     (req_ready),
    .accept    (ev_accept),
    .issue     (ev_issue),
    .capture   (ev_capture),
    .finish    (ev_finish)
  );

  ptw_addr_gen #(.VA_W(VA_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_addr (
    .va         (va_q),
    .base       (base_q),
    .entry_addr (entry_addr),
    .offset     (offset)
  );

  ptw_check #(.PFN_W(PFN_W), .OFF_W(OFF_W)) u_check (
    .pte      (mem_rsp_data),
    .is_write (write_q),
    .offset   (offset),
    .result   (chk_result),
    .pa       (chk_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q    <= '0;
      write_q <= 1'b0;
      base_q  <= '0;
    end else if (ev_accept) begin
      va_q    <= req_va;
      write_q <= req_write;
      base_q  <= table_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_q     <= '0;
      absent_q <= 1'b0;
      perm_q   <= 1'b0;
    end else if (ev_capture) begin
      pa_q     <= chk_pa;
      absent_q <= (chk_result == RES_ABSENT);
      perm_q   <= (chk_result == RES_PERM);
    end
  end

  always_comb begin
    mem_req_valid = ev_issue;
    mem_req_addr  = entry_addr;
    done          = ev_finish;
    pa            = ev_finish ? pa_q : '0;
    fault_absent  = ev_finish && absent_q;
    fault_perm    = ev_finish && perm_q;
  end

  // R2: a walk makes one read only.
  assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R2: the page-number field of the read address comes from the accepted VA.
  assert_entry_vpn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[VPN_W-1:0] == $past(req_va[VA_W-1:OFF_W])));

  // R3: no new request is taken while a read is outstanding.
  assert_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R8: done is a single-cycle strobe.
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: faults appear only with done, and never both at once.
  assert_fault_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_absent || fault_perm) |-> (done && !(fault_absent && fault_perm)));

  // R5: a missing page yields no address.
  assert_absent_zero_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_absent |-> (pa == '0));

  // R7: the displacement reaches the physical address unchanged.
  assert_offset_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault_absent && !fault_perm) |-> (pa[OFF_W-1:0] == va_q[OFF_W-1:0]));

endmodule

// File: tb/sim_ptw_unit.sv
`timescale 1ns/1ps
module sim_ptw_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_va;
  logic        req_write;
  logic [7:0]  table_base;
  logic        mem_req_valid;
  logic [13:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [10:0] mem_rsp_data;
  logic        done;
  logic [17:0] pa;
  logic        fault_absent;
  logic        fault_perm;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  ptw_unit u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .req_write     (req_write),
    .table_base    (table_base),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (done),
    .pa            (pa),
    .fault_absent  (fault_absent),
    .fault_perm    (fault_perm)
  );

  // Vector: {va[16], write[1], base[8], pte[11], latency[4], outcome[2]}
  // outcome 0 = translated, 1 = not present, 2 = protection
  localparam int NV = 8;
  localparam logic [41:0] VEC [NV] = '{
    {16'h0000, 1'b0, 8'h00, 11'h007, 4'd1, 2'd0},
    {16'hFFFF, 1'b1, 8'hFF, 11'h7FF, 4'd3, 2'd0},
    {16'h1234, 1'b0, 8'hA5, 11'h1E5, 4'd2, 2'd0},
    {16'h1234, 1'b1, 8'hA5, 11'h1E5, 4'd2, 2'd2},
    {16'h8C01, 1'b1, 8'h5A, 11'h08E, 4'd4, 2'd1},
    {16'h0400, 1'b0, 8'h01, 11'h113, 4'd1, 2'd2},
    {16'h7BFF, 1'b1, 8'hC3, 11'h40B, 4'd9, 2'd0},
    {16'h03FF, 1'b0, 8'h80, 11'h000, 4'd15, 2'd1}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One walk, entered and left at a falling edge with the unit idle.
  task automatic walk(input logic [15:0] va, input logic wr, input logic [7:0] base,
                      input logic [10:0] pte, input int lat, input int outcome,
                      input bit intrude);
    int exp_addr;
    int exp_pa;
    int frame;
    frame    = (int'(pte) / 8) % 256;
    exp_addr = int'(base) * 64 + int'(va) / 1024;
    exp_pa   = (outcome == 0) ? frame * 1024 + int'(va) % 1024 : 0;

    check(req_ready == 1'b1, "R3 ready before request", 32'(req_ready), 1);
    req_valid  = 1'b1;
    req_va     = va;
    req_write  = wr;
    table_base = base;
    @(negedge clk);
    req_valid  = 1'b0;
    table_base = ~base;
    req_va     = ~va;
    check(mem_req_valid == 1'b1, "R2 read issued after accept", 32'(mem_req_valid), 1);
    check(32'(mem_req_addr) == 32'(exp_addr), "R2 entry address",
          32'(mem_req_addr), 32'(exp_addr));
    check(req_ready == 1'b0, "R3 busy during walk", 32'(req_ready), 0);

    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      check(!done && !mem_req_valid, "R9 nothing while awaiting response",
            32'({done, mem_req_valid}), 0);
      if (intrude && i == 0) begin
        req_valid = 1'b1;
        req_va    = va ^ 16'hA5A5;
        req_write = ~wr;
      end
    end
    req_valid     = 1'b0;
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 11'h7FF;

    check(done == 1'b1, "R8 done after response", 32'(done), 1);
    case (outcome)
      0: check(!fault_absent && !fault_perm && 32'(pa) == 32'(exp_pa),
               "R7 R4 translated address", 32'(pa), 32'(exp_pa));
      1: check(fault_absent && !fault_perm && pa == '0,
               "R5 not-present fault", 32'({fault_absent, fault_perm, pa}), 32'h80000);
      default: check(!fault_absent && fault_perm && pa == '0,
               "R6 protection fault", 32'({fault_absent, fault_perm, pa}), 32'h40000);
    endcase

    @(negedge clk);
    check(!done && !fault_absent && !fault_perm && pa == '0, "R8 single done cycle",
          32'({done, fault_absent, fault_perm}), 0);
    check(req_ready && !mem_req_valid, "R3 idle again, no extra read",
          32'({req_ready, mem_req_valid}), 32'h2);
  endtask

  task automatic run_all();
    req_valid     = 1'b0;
    req_va        = '0;
    req_write     = 1'b0;
    table_base    = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    rst_n         = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: state out of reset
    check(req_ready && !done && !fault_absent && !fault_perm && !mem_req_valid && pa == '0,
          "R1 reset state", 32'({req_ready, done, fault_absent, fault_perm, mem_req_valid}),
          32'h10);

    for (int v = 0; v < NV; v++) begin
      walk(VEC[v][41:26], VEC[v][25], VEC[v][24:17], VEC[v][16:6],
           int'(VEC[v][5:2]), int'(VEC[v][1:0]), 1'b0);
    end

    // R3: a request raised mid-walk must not disturb the walk
    walk(16'h2C55, 1'b0, 8'h3E, 11'h2D5, 4, 0, 1'b1);

    // R9: a response while idle is ignored
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 11'h7FF;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check(!done && !mem_req_valid && req_ready, "R9 stray response ignored",
          32'({done, mem_req_valid, req_ready}), 1);
    @(negedge clk);
    check(!done && req_ready, "R9 still idle after stray response",
          32'({done, req_ready}), 1);

    // R5: not present even with every right granted
    walk(16'hF000, 1'b1, 8'h11, 11'h7FE, 2, 1, 1'b0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual hung expected finished");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule